// File: doc/BRIEF.md
# Slave Register Bridge with Polled Read Command

This block connects a memory-mapped host to the register file of an attached slave device. It sits on a simple single-cycle host bus. On the slave side it drives a request/acknowledge register port, and the slave may take any number of cycles to respond. Host writes that land in an address window above the bridge's own registers are turned into slave writes. Each one is queued as an (offset, data) pair in a small write FIFO and issued to the slave one at a time, in order.

A slave read is started when the host stores the wanted slave offset into a command register. A busy flag then appears in the read-result register. The host polls that register until busy drops. It then finds the 16-bit value together with a 15-bit echo of the offset that was read, which it uses to confirm that the data belongs to its own request. A read is held back until every queued write has reached the slave, so reads never overtake earlier writes.

Offsets outside the slave window are refused and never reach the slave. Such refusals, and writes lost because the FIFO is full, leave sticky flags in an error register that the host clears by writing ones.

Top module: `regbridge_top`

## Requirements
- R1: After reset the read-result register reads 0 (busy clear), the FIFO status register reads with bit 10 (empty) set and bit 11 (full) clear, the error register reads 0, and `slv_req` is low.
- R2: A host write to byte address 0x28 with a value below 2^SLV_AW makes busy (bit 31 of the read-result register at 0x2C) read 1 from the next cycle on, and leads to one slave read request (`slv_we`=0) at that offset.
- R3: When the slave acknowledges the read, busy clears. Bits 15:0 of the read-result register then hold `slv_rdata`, and bits 30:16 hold bits 16:2 of the commanded offset. The echo is already present while busy is high.
- R4: A host write to address WIN_BASE+k (k below 2^SLV_AW) reaches the slave as a write of `host_wdata[15:0]` to offset k. Queued writes are issued in arrival order, with at most one request outstanding, and the request signals stay stable until acknowledged.
- R5: The FIFO status register at 0x30 shows bit 11 = full and bit 10 = empty. The FIFO holds 8 entries.
- R6: A window write while the FIFO is full is discarded and sets the sticky overflow flag, bit 1 of the error register at 0x34.
- R7: A read command with an offset of 2^SLV_AW or more, or a window write whose offset is 2^SLV_AW or more, is refused. It causes no slave access and no busy, and it sets the sticky range flag, bit 0 of the error register.
- R8: A pending read is issued to the slave only after the write FIFO is empty, so a read of an offset just written returns the written value.
- R9: A read command written while busy is high is ignored. The echo keeps the first offset and only one slave read takes place.
- R10: Writing to 0x34 clears each error flag whose bit is 1 in the written value and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte address for both reads and writes |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |
| slv_req | output | 1 | Slave request, held until acknowledged |
| slv_we | output | 1 | 1 = slave write, 0 = slave read |
| slv_addr | output | SLV_AW | Slave register offset |
| slv_wdata | output | DATA_W | Slave write data |
| slv_ack | input | 1 | Slave acknowledge, one cycle |
| slv_rdata | input | DATA_W | Slave read data, valid with `slv_ack` |

## Verification
Reads are driven at short and long slave latencies, and at an offset at the top of the window. This shows that busy tracks the slave handshake and that the echo is taken from bits 16:2 rather than the low bits. A run of writes to scattered offsets, including the highest legal one, shows that the drain preserves order and payload. A write followed at once by a read of the same offset can only return the new value if reads wait for the FIFO to empty. With the slave stalled, writes keep arriving until they fill the FIFO, overflow it, and expose the full flag and the dropped entry. A second command issued during a read, and offsets one past the window, show that ignored or refused requests leave no trace at the slave port while the sticky flags clear bit by bit.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;
   // Host-visible register byte offsets inside the bridge
   localparam int unsigned OFF_RD_CMD   = 'h28;
   localparam int unsigned OFF_RD_RES   = 'h2C;
   localparam int unsigned OFF_WQ_STAT  = 'h30;
   localparam int unsigned OFF_ERR_FLAG = 'h34;

   // Field positions the host software decodes
   localparam int unsigned BUSY_BIT     = 31;
   localparam int unsigned Q_FULL_BIT   = 11;
   localparam int unsigned Q_EMPTY_BIT  = 10;
   localparam int unsigned ERR_RANGE    = 0;
   localparam int unsigned ERR_OVF      = 1;
   localparam int unsigned ECHO_W       = 15;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WRITE = 2'd1,
      SEQ_READ  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/regbridge_wfifo.sv
module regbridge_wfifo #(
   parameter int WIDTH = 33,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = PW + 1;

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("regbridge_wfifo: DEPTH must be a power of two and at least 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = store[rptr];

   always_ff @(posedge clk) begin
      if (do_push) store[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R6: a push offered while full must not change occupancy
   a_r6_full_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> full);
   // R5: occupancy never exceeds the configured depth
   a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/regbridge_slvseq.sv
module regbridge_slvseq
   import regbridge_pkg::*;
#(
   parameter int SLV_AW = 17,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [SLV_AW-1:0] q_addr,
   input  logic [DATA_W-1:0] q_data,
   output logic              q_pop,
   input  logic              rd_busy,
   input  logic [SLV_AW-1:0] rd_addr,
   output logic              rd_done,
   output logic [DATA_W-1:0] rd_value,
   output logic              slv_req,
   output logic              slv_we,
   output logic [SLV_AW-1:0] slv_addr,
   output logic [DATA_W-1:0] slv_wdata,
   input  logic              slv_ack,
   input  logic [DATA_W-1:0] slv_rdata
);
   seq_state_e state;

   // Queued writes take priority over a waiting read, so reads never pass writes
   assign q_pop    = (state == SEQ_IDLE) && !q_empty;
   assign rd_done  = (state == SEQ_READ) && slv_ack;
   assign rd_value = slv_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SEQ_IDLE;
         slv_req   <= 1'b0;
         slv_we    <= 1'b0;
         slv_addr  <= '0;
         slv_wdata <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (!q_empty) begin
                  state     <= SEQ_WRITE;
                  slv_req   <= 1'b1;
                  slv_we    <= 1'b1;
                  slv_addr  <= q_addr;
                  slv_wdata <= q_data;
               end else if (rd_busy) begin
                  state     <= SEQ_READ;
                  slv_req   <= 1'b1;
                  slv_we    <= 1'b0;
                  slv_addr  <= rd_addr;
                  slv_wdata <= '0;
               end
            end
            SEQ_WRITE, SEQ_READ: begin
               if (slv_ack) begin
                  state   <= SEQ_IDLE;
                  slv_req <= 1'b0;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // R4: an unacknowledged request holds its command fields
   a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_req && !slv_ack) |=>
         (slv_req && $stable(slv_addr) && $stable(slv_we) && $stable(slv_wdata)));
   // R8: a slave read starts only from an empty write queue
   a_r8_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(slv_req) && !slv_we) |-> $past(q_empty));
endmodule

// File: rtl/regbridge_hostif.sv
module regbridge_hostif
   import regbridge_pkg::*;
#(
   parameter int          HOST_AW   = 20,
   parameter int          SLV_AW    = 17,
   parameter int          DATA_W    = 16,
   parameter int unsigned WIN_BASE  = 'h20000,
   parameter bit          ECHO_WORD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   input  logic               q_full,
   input  logic               q_empty,
   output logic               q_push,
   output logic [SLV_AW-1:0]  q_addr,
   output logic [DATA_W-1:0]  q_data,
   output logic               rd_busy,
   output logic [SLV_AW-1:0]  rd_addr,
   input  logic               rd_done,
   input  logic [DATA_W-1:0]  rd_value
);
   logic [HOST_AW-1:0] win_off;
   logic               in_win, win_ok;
   logic               reg_we, cmd_hit, cmd_ok, cmd_bad;
   logic               win_hit, win_bad, win_drop, clr_hit;
   logic [DATA_W-1:0]  rd_val;
   logic [ECHO_W-1:0]  echo;
   logic               err_range, err_ovf;

   assign in_win  = (host_addr >= HOST_AW'(WIN_BASE));
   assign win_off = host_addr - HOST_AW'(WIN_BASE);
   assign win_ok  = ((win_off >> SLV_AW) == '0);

   assign reg_we   = host_we && !in_win;
   assign cmd_hit  = reg_we && (host_addr == HOST_AW'(OFF_RD_CMD));
   assign cmd_ok   = cmd_hit && ((host_wdata >> SLV_AW) == 32'd0);
   assign cmd_bad  = cmd_hit && !cmd_ok;
   assign clr_hit  = reg_we && (host_addr == HOST_AW'(OFF_ERR_FLAG));
   assign win_hit  = host_we && in_win;
   assign win_bad  = win_hit && !win_ok;
   assign q_push   = win_hit && win_ok && !q_full;
   assign win_drop = win_hit && win_ok && q_full;
   assign q_addr   = win_off[SLV_AW-1:0];
   assign q_data   = host_wdata[DATA_W-1:0];

   // Echo variant: word-granular offsets drop the two always-zero low bits
   if (ECHO_WORD) begin : g_echo_word
      assign echo = rd_addr[ECHO_W+1:2];
   end else begin : g_echo_flat
      assign echo = rd_addr[ECHO_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_busy <= 1'b0;
         rd_addr <= '0;
         rd_val  <= '0;
      end else begin
         if (rd_done) begin
            rd_busy <= 1'b0;
            rd_val  <= rd_value;
         end else if (cmd_ok && !rd_busy) begin
            rd_busy <= 1'b1;
            rd_addr <= host_wdata[SLV_AW-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_range <= 1'b0;
         err_ovf   <= 1'b0;
      end else begin
         err_range <= (err_range && !(clr_hit && host_wdata[ERR_RANGE]))
                      || cmd_bad || win_bad;
         err_ovf   <= (err_ovf && !(clr_hit && host_wdata[ERR_OVF])) || win_drop;
      end
   end

   always_comb begin
      host_rdata = '0;
      if (!in_win) begin
         if (host_addr == HOST_AW'(OFF_RD_RES)) begin
            host_rdata = {rd_busy, echo, rd_val};
         end else if (host_addr == HOST_AW'(OFF_WQ_STAT)) begin
            host_rdata[Q_FULL_BIT]  = q_full;
            host_rdata[Q_EMPTY_BIT] = q_empty;
         end else if (host_addr == HOST_AW'(OFF_ERR_FLAG)) begin
            host_rdata[ERR_RANGE] = err_range;
            host_rdata[ERR_OVF]   = err_ovf;
         end
      end
   end

   // R2: an accepted command raises busy on the next cycle
   a_r2_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ok && !rd_busy) |=> rd_busy);
   // R3: completion always drops busy
   a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_busy);
   // R9: a command during busy leaves the latched offset alone
   a_r9_cmd_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_busy && cmd_hit) |=> $stable(rd_addr));
   // R7: a refused offset raises the range flag
   a_r7_range_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_bad || win_bad) |=> err_range);
   // R6: a dropped write raises the overflow flag
   a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
      win_drop |=> err_ovf);
endmodule

// File: rtl/regbridge_top.sv
module regbridge_top
   import regbridge_pkg::*;
#(
   parameter int          HOST_AW    = 20,
   parameter int          SLV_AW     = 17,
   parameter int          DATA_W     = 16,
   parameter int          FIFO_DEPTH = 8,
   parameter int unsigned WIN_BASE   = 'h20000,
   parameter bit          ECHO_WORD  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               slv_req,
   output logic               slv_we,
   output logic [SLV_AW-1:0]  slv_addr,
   output logic [DATA_W-1:0]  slv_wdata,
   input  logic               slv_ack,
   input  logic [DATA_W-1:0]  slv_rdata
);
   localparam int QW = SLV_AW + DATA_W;

   if (DATA_W != 16) begin : g_bad_data
      $error("regbridge_top: read-result layout needs DATA_W == 16");
   end
   if ((ECHO_WORD && SLV_AW < ECHO_W + 2) || (!ECHO_WORD && SLV_AW < ECHO_W)) begin : g_bad_echo
      $error("regbridge_top: SLV_AW too narrow for the selected echo variant");
   end
   if (SLV_AW > 30 || WIN_BASE < 'h40 ||
       (longint'(WIN_BASE) + (longint'(1) << SLV_AW)) > (longint'(1) << HOST_AW)) begin : g_bad_map
      $error("regbridge_top: slave window does not fit the host address map");
   end

   logic              q_push, q_pop, q_full, q_empty;
   logic [SLV_AW-1:0] q_in_addr;
   logic [DATA_W-1:0] q_in_data;
   logic [QW-1:0]     q_head;
   logic              rd_busy, rd_done;
   logic [SLV_AW-1:0] rd_addr;
   logic [DATA_W-1:0] rd_value;

   regbridge_hostif #(
      .HOST_AW(HOST_AW), .SLV_AW(SLV_AW), .DATA_W(DATA_W),
      .WIN_BASE(WIN_BASE), .ECHO_WORD(ECHO_WORD)
   ) u_hostif (
      .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
      .q_full, .q_empty, .q_push, .q_addr(q_in_addr), .q_data(q_in_data),
      .rd_busy, .rd_addr, .rd_done, .rd_value
   );

   regbridge_wfifo #(.WIDTH(QW), .DEPTH(FIFO_DEPTH)) u_wfifo (
      .clk, .rst_n,
      .push(q_push), .din({q_in_addr, q_in_data}),
      .pop(q_pop), .dout(q_head),
      .full(q_full), .empty(q_empty)
   );

   regbridge_slvseq #(.SLV_AW(SLV_AW), .DATA_W(DATA_W)) u_slvseq (
      .clk, .rst_n,
      .q_empty, .q_addr(q_head[QW-1:DATA_W]), .q_data(q_head[DATA_W-1:0]),
      .q_pop, .rd_busy, .rd_addr, .rd_done, .rd_value,
      .slv_req, .slv_we, .slv_addr, .slv_wdata, .slv_ack, .slv_rdata
   );

   // R1: no slave traffic is requested while in reset
   a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |-> !slv_req);
endmodule

// File: tb/tb_regbridge_top.sv
module tb_regbridge_top;
   localparam int AW = 20;
   localparam int SW = 17;
   localparam int WB = 'h20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [31:0]   host_wdata = '0;
   logic [31:0]   host_rdata;
   logic          slv_req, slv_we;
   logic [SW-1:0] slv_addr;
   logic [15:0]   slv_wdata;
   logic          slv_ack = 1'b0;
   logic [15:0]   slv_rdata = '0;

   int   n_checks = 0, n_errors = 0;
   int   lat = 1;
   bit   done = 1'b0;

   // Slave model log and memory
   logic [SW-1:0] log_addr [0:63];
   logic [15:0]   log_data [0:63];
   logic          log_we   [0:63];
   int            log_n = 0;
   int            cnt = 0;
   logic [15:0]   smem [int];

   regbridge_top dut (
      .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
      .slv_req, .slv_we, .slv_addr, .slv_wdata, .slv_ack, .slv_rdata
   );

   always #10 clk = ~clk;

   function automatic logic [15:0] dflt(input logic [SW-1:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   // Slave with programmable latency, acting on falling edges
   always @(negedge clk) begin
      if (!rst_n) begin
         slv_ack <= 1'b0;
         cnt = 0;
      end else if (slv_ack) begin
         slv_ack <= 1'b0;
      end else if (slv_req) begin
         if (cnt >= lat - 1) begin
            cnt = 0;
            if (log_n < 64) begin
               log_addr[log_n] = slv_addr;
               log_data[log_n] = slv_wdata;
               log_we[log_n]   = slv_we;
            end
            log_n++;
            if (slv_we) smem[int'(slv_addr)] = slv_wdata;
            else slv_rdata <= smem.exists(int'(slv_addr)) ? smem[int'(slv_addr)] : dflt(slv_addr);
            slv_ack <= 1'b1;
         end else begin
            cnt++;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hread(input logic [AW-1:0] a, output logic [31:0] v);
      @(negedge clk);
      host_addr = a;
      #2 v = host_rdata;
   endtask

   task automatic wait_read(output logic [31:0] v);
      for (int i = 0; i < 2000; i++) begin
         hread(20'h2C, v);
         if (!v[31]) break;
      end
   endtask

   task automatic wait_drain();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         hread(20'h30, v);
         if (v[10] && !slv_req) break;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      hread(20'h2C, v); check("R1 read-result", v, 32'h0);
      hread(20'h30, v); check("R1 fifo status", v, 32'h400);
      hread(20'h34, v); check("R1 error flags", v, 32'h0);
      check("R1 slv_req", {31'd0, slv_req}, 32'd0);
   endtask

   task automatic t_read_short();
      logic [31:0] v;
      int n0;
      lat = 1; n0 = log_n;
      hwrite(20'h28, 32'h124);
      wait_read(v);
      check("R3 value+echo short", v, {1'b0, 15'h49, dflt(17'h124)});
      check("R2 one slave read", log_n - n0, 1);
      check("R2 read offset", {15'd0, log_addr[n0]}, 32'h124);
      check("R2 read direction", {31'd0, log_we[n0]}, 32'd0);
   endtask

   task automatic t_read_long();
      logic [31:0] v;
      lat = 8;
      hwrite(20'h28, 32'h1FFFC);
      hread(20'h2C, v);
      check("R2 busy set after command", {31'd0, v[31]}, 32'd1);
      check("R3 echo while busy", {17'd0, v[30:16]}, 32'h7FFF);
      wait_read(v);
      check("R3 value+echo long", v, {1'b0, 15'h7FFF, dflt(17'h1FFFC)});
   endtask

   task automatic t_write_order();
      int n0;
      lat = 2; n0 = log_n;
      hwrite(WB + 20'h10,    32'hFFFF1111);
      hwrite(WB + 20'h1FFFC, 32'h2222);
      hwrite(WB + 20'hABC,   32'h3333);
      wait_drain();
      check("R4 write count", log_n - n0, 3);
      check("R4 first", {log_we[n0], log_addr[n0], log_data[n0]}, {1'b1, 17'h10, 16'h1111});
      check("R4 second", {log_we[n0+1], log_addr[n0+1], log_data[n0+1]}, {1'b1, 17'h1FFFC, 16'h2222});
      check("R4 third", {log_we[n0+2], log_addr[n0+2], log_data[n0+2]}, {1'b1, 17'hABC, 16'h3333});
   endtask

   task automatic t_read_after_write();
      logic [31:0] v;
      lat = 3;
      hwrite(WB + 20'h100, 32'hBEEF);
      hwrite(WB + 20'h104, 32'hCAFE);
      hwrite(20'h28, 32'h100);
      wait_read(v);
      check("R8 read sees queued write", v, {1'b0, 15'h40, 16'hBEEF});
      wait_drain();
   endtask

   task automatic t_fifo_full();
      logic [31:0] v;
      int n0;
      lat = 300; n0 = log_n;
      for (int i = 0; i < 9; i++) hwrite(WB + 20'(i * 4 + 'h400), 32'(i + 'h50));
      hread(20'h30, v);
      check("R5 full after 8 queued", v, 32'h800);
      hread(20'h34, v);
      check("R6 no overflow yet", v, 32'h0);
      hwrite(WB + 20'h800, 32'h9999);
      hread(20'h34, v);
      check("R6 overflow flag", v, 32'h2);
      wait_drain();
      check("R6 dropped write absent", log_n - n0, 9);
      check("R4 last drained", {15'd0, log_addr[n0+8]}, 32'h420);
      hread(20'h30, v);
      check("R5 empty after drain", v, 32'h400);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      int n0;
      lat = 20; n0 = log_n;
      hwrite(20'h28, 32'h200);
      hwrite(20'h28, 32'h300);
      hread(20'h2C, v);
      check("R9 echo keeps first offset", {17'd0, v[30:16]}, 32'h80);
      wait_read(v);
      check("R9 first read result", v, {1'b0, 15'h80, dflt(17'h200)});
      repeat (30) @(negedge clk);
      check("R9 single slave read", log_n - n0, 1);
   endtask

   task automatic t_range();
      logic [31:0] v;
      int n0;
      lat = 1; n0 = log_n;
      hwrite(20'h28, 32'h20000);
      hread(20'h2C, v);
      check("R7 refused command no busy", v, {1'b0, 15'h80, dflt(17'h200)});
      hread(20'h34, v);
      check("R7 range flag", v, 32'h3);
      hwrite(20'h34, 32'h1);
      hread(20'h34, v);
      check("R10 clear range only", v, 32'h2);
      hwrite(20'h40000, 32'h1234);
      repeat (10) @(negedge clk);
      check("R7 no slave access", log_n - n0, 0);
      hread(20'h30, v);
      check("R7 fifo untouched", v, 32'h400);
      hread(20'h34, v);
      check("R7 window range flag", v, 32'h3);
      hwrite(20'h34, 32'h2);
      hread(20'h34, v);
      check("R10 clear overflow only", v, 32'h1);
      hwrite(20'h34, 32'h1);
      hread(20'h34, v);
      check("R10 all clear", v, 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_read_short();
      t_read_long();
      t_write_order();
      t_read_after_write();
      t_fifo_full();
      t_busy_ignore();
      t_range();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule